// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit

This unit computes one arithmetic, logical or compare operation per clock on two 32-bit operands for a small load/store processor. A 4-bit operation code selects signed or unsigned addition and subtraction, one of four bitwise functions, or a signed or unsigned less-than compare. Alongside the 32-bit result it reports a carry, a signed overflow and a zero flag.

Operands are expected to be already extended by the surrounding datapath. Subtraction and both compares share a single lookahead adder: the second operand is inverted and the carry-in is forced high.

The result and all three flags are captured in an output register, so they appear one clock after the operands and code are presented. A synchronous active-high reset clears that register.

Top module: `int_alu`

## Requirements
- R1: Code 0 (signed add) gives A+B modulo 2^32. Carry is the carry out of bit 31. Overflow is 1 when both operands have the same sign and the sum's sign differs from it.
- R2: Code 1 (unsigned add) gives the same sum and carry as code 0, with overflow always 0.
- R3: Code 2 (signed subtract) gives A-B modulo 2^32. Carry is the carry out of A + ~B + 1. Overflow is 1 when the operand signs differ and the result's sign differs from A's.
- R4: Code 3 (unsigned subtract) gives the same result and carry as code 2, with overflow always 0.
- R5: Code 4 gives A&B, code 5 gives A|B, code 6 gives A^B and code 7 gives ~(A|B). All four drive carry and overflow to 0.
- R6: Code 12 gives 1 in bit 0 when A < B as two's-complement numbers, and 0 otherwise. This holds even when A-B overflows. Bits 31..1 are 0, carry is 0, and overflow reports the overflow of A-B.
- R7: Code 13 gives 1 in bit 0 when A < B as unsigned numbers, and 0 otherwise. Bits 31..1 are 0, and carry and overflow are 0.
- R8: Codes 8, 9, 10, 11, 14 and 15 give a zero result with carry and overflow at 0.
- R9: The zero flag is 1 exactly when all 32 result bits are 0.
- R10: Outputs show the operation sampled at the previous rising clock edge. While reset is high at an edge, result, carry and overflow are cleared to 0 and zero is set to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_code | input | 4 | Operation select |
| result | output | 32 | Registered result |
| carry_out | output | 1 | Registered carry |
| overflow | output | 1 | Registered signed overflow |
| zero | output | 1 | Registered all-zero flag of the result |

## Verification
The signed compare and overflow detection land in the same cycle. Code 12 runs a subtraction whose overflow must be reported, and that same overflow must flip the sign-based less-than decision. This is provoked with operand pairs such as 0x80000000 against 1 and 0x7FFFFFFF against 0xFFFFFFFF. In each, A-B wraps around. The scoreboard computes the compare from native signed arithmetic, and the overflow from the operand and result signs, and checks both in the same output word. Random operands over all valid codes add further pairs where the two coincide.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    OPC_ADD   = 4'd0,
    OPC_ADDU  = 4'd1,
    OPC_SUB   = 4'd2,
    OPC_SUBU  = 4'd3,
    OPC_AND   = 4'd4,
    OPC_OR    = 4'd5,
    OPC_XOR   = 4'd6,
    OPC_NOR   = 4'd7,
    OPC_SLT   = 4'd12,
    OPC_SLTU  = 4'd13
  } opc_e;

  typedef enum logic [1:0] {
    SEL_SUM   = 2'd0,
    SEL_LOGIC = 2'd1,
    SEL_CMP   = 2'd2,
    SEL_NONE  = 2'd3
  } res_sel_e;

  typedef enum logic [1:0] {
    LF_AND = 2'd0,
    LF_OR  = 2'd1,
    LF_XOR = 2'd2,
    LF_NOR = 2'd3
  } logic_fn_e;

  typedef struct packed {
    logic      invert_b;
    res_sel_e  sel;
    logic_fn_e lfn;
    logic      cmp_signed;
    logic      carry_en;
    logic      ovf_en;
  } alu_ctrl_t;

endpackage

// File: rtl/int_alu_decode.sv
module int_alu_decode
  import int_alu_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output alu_ctrl_t         ctrl
);

  always_comb begin
    ctrl            = '0;
    ctrl.sel        = SEL_NONE;
    ctrl.lfn        = LF_AND;
    case (code)
      OPC_ADD: begin
        ctrl.sel      = SEL_SUM;
        ctrl.carry_en = 1'b1;
        ctrl.ovf_en   = 1'b1;
      end
      OPC_ADDU: begin
        ctrl.sel      = SEL_SUM;
        ctrl.carry_en = 1'b1;
      end
      OPC_SUB: begin
        ctrl.sel      = SEL_SUM;
        ctrl.invert_b = 1'b1;
        ctrl.carry_en = 1'b1;
        ctrl.ovf_en   = 1'b1;
      end
      OPC_SUBU: begin
        ctrl.sel      = SEL_SUM;
        ctrl.invert_b = 1'b1;
        ctrl.carry_en = 1'b1;
      end
      OPC_AND: begin
        ctrl.sel = SEL_LOGIC;
        ctrl.lfn = LF_AND;
      end
      OPC_OR: begin
        ctrl.sel = SEL_LOGIC;
        ctrl.lfn = LF_OR;
      end
      OPC_XOR: begin
        ctrl.sel = SEL_LOGIC;
        ctrl.lfn = LF_XOR;
      end
      OPC_NOR: begin
        ctrl.sel = SEL_LOGIC;
        ctrl.lfn = LF_NOR;
      end
      OPC_SLT: begin
        ctrl.sel        = SEL_CMP;
        ctrl.invert_b   = 1'b1;
        ctrl.cmp_signed = 1'b1;
        ctrl.ovf_en     = 1'b1;
      end
      OPC_SLTU: begin
        ctrl.sel      = SEL_CMP;
        ctrl.invert_b = 1'b1;
      end
      default: ctrl.sel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/int_alu_cla.sv
module int_alu_cla #(
  parameter int WIDTH = 32,
  parameter int GRP   = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             c_into_msb,
  output logic             c_out
);

  localparam int NGRP = WIDTH / GRP;

  logic [WIDTH-1:0] prop;
  logic [WIDTH-1:0] gen;
  logic [WIDTH-1:0] c_bit;
  logic [NGRP:0]    c_grp;

  assign prop     = a ^ b;
  assign gen      = a & b;
  assign c_grp[0] = cin;

  for (genvar gi = 0; gi < NGRP; gi++) begin : g_group
    logic [GRP-1:0] p_loc;
    logic [GRP-1:0] g_loc;
    logic [GRP:0]   c_loc;
    logic           grp_g;
    logic           grp_p;

    assign p_loc = prop[gi*GRP +: GRP];
    assign g_loc = gen[gi*GRP +: GRP];

    // group generate / propagate for the lookahead chain
    always_comb begin
      grp_g = 1'b0;
      grp_p = 1'b1;
      for (int j = 0; j < GRP; j++) begin
        grp_g = g_loc[j] | (p_loc[j] & grp_g);
        grp_p = grp_p & p_loc[j];
      end
    end

    assign c_grp[gi+1] = grp_g | (grp_p & c_grp[gi]);

    // carries inside the group, seeded by the group carry-in
    always_comb begin
      c_loc[0] = c_grp[gi];
      for (int j = 0; j < GRP; j++) begin
        c_loc[j+1] = g_loc[j] | (p_loc[j] & c_loc[j]);
      end
    end

    assign c_bit[gi*GRP +: GRP] = c_loc[GRP-1:0];
  end

  assign sum        = prop ^ c_bit;
  assign c_into_msb = c_bit[WIDTH-1];
  assign c_out      = c_grp[NGRP];

endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic_fn_e        fn,
  output logic [WIDTH-1:0] y
);

  always_comb begin
    case (fn)
      LF_AND:  y = a & b;
      LF_OR:   y = a | b;
      LF_XOR:  y = a ^ b;
      default: y = ~(a | b);
    endcase
  end

endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int GRP   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [WIDTH-1:0]    op_a,
  input  logic [WIDTH-1:0]    op_b,
  input  logic [CODE_W-1:0]   op_code,
  output logic [WIDTH-1:0]    result,
  output logic                carry_out,
  output logic                overflow,
  output logic                zero
);

  localparam int MSB = WIDTH - 1;

  alu_ctrl_t        ctrl;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] sum;
  logic             c_into_msb;
  logic             c_out;
  logic             ovf_raw;
  logic             lt_signed;
  logic             lt_unsigned;
  logic             lt_sel;
  logic [WIDTH-1:0] logic_y;
  logic [WIDTH-1:0] res_next;
  logic             carry_next;
  logic             ovf_next;

  int_alu_decode u_decode (
    .code (op_code),
    .ctrl (ctrl)
  );

  assign b_eff = ctrl.invert_b ? ~op_b : op_b;

  int_alu_cla #(.WIDTH(WIDTH), .GRP(GRP)) u_adder (
    .a          (op_a),
    .b          (b_eff),
    .cin        (ctrl.invert_b),
    .sum        (sum),
    .c_into_msb (c_into_msb),
    .c_out      (c_out)
  );

  int_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a  (op_a),
    .b  (op_b),
    .fn (ctrl.lfn),
    .y  (logic_y)
  );

  assign ovf_raw     = c_into_msb ^ c_out;
  assign lt_signed   = sum[MSB] ^ ovf_raw;
  assign lt_unsigned = ~c_out;
  assign lt_sel      = ctrl.cmp_signed ? lt_signed : lt_unsigned;

  always_comb begin
    case (ctrl.sel)
      SEL_SUM:   res_next = sum;
      SEL_LOGIC: res_next = logic_y;
      SEL_CMP:   res_next = {{(WIDTH-1){1'b0}}, lt_sel};
      default:   res_next = '0;
    endcase
  end

  assign carry_next = ctrl.carry_en & c_out;
  assign ovf_next   = ctrl.ovf_en & ovf_raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      carry_out <= 1'b0;
      overflow  <= 1'b0;
      zero      <= 1'b1;
    end else begin
      result    <= res_next;
      carry_out <= carry_next;
      overflow  <= ovf_next;
      zero      <= ~|res_next;
    end
  end

  // ---------------- assertions ----------------
  p_add_sum_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_code) == 4'd0) |-> result == $past(op_a + op_b));

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_code) == 4'd1) |-> !overflow);

  p_sub_diff_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_code) == 4'd2) |-> result == $past(op_a - op_b));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_code) == 4'd3) |-> !overflow);

  p_logic_flags_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_code) >= 4'd4 && $past(op_code) <= 4'd7)
      |-> (!carry_out && !overflow));

  p_cmp_upper_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_code) == 4'd12 || $past(op_code) == 4'd13))
      |-> (result[MSB:1] == '0 && !carry_out));

  p_sltu_bit_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_code) == 4'd13)
      |-> (result[0] == ($past(op_a) < $past(op_b)) && !overflow));

  p_unused_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_code) inside {4'd8, 4'd9, 4'd10, 4'd11, 4'd14, 4'd15}))
      |-> (result == '0 && !carry_out && !overflow));

  p_zero_flag_r9: assert property (@(posedge clk) disable iff (rst)
    zero == (result == '0));

  p_reset_state_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (result == '0 && zero && !carry_out && !overflow));

endmodule

// File: tb/int_alu_test.sv
module int_alu_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_a = 32'h1234_5678;
  logic [31:0] op_b = 32'h0F0F_0F0F;
  logic [3:0]  op_code = 4'd0;
  logic [31:0] result;
  logic        carry_out;
  logic        overflow;
  logic        zero;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] r;
    logic        c;
    logic        v;
    logic        z;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  always #4 clk = ~clk;

  int_alu uut (
    .clk       (clk),
    .rst       (rst),
    .op_a      (op_a),
    .op_b      (op_b),
    .op_code   (op_code),
    .result    (result),
    .carry_out (carry_out),
    .overflow  (overflow),
    .zero      (zero)
  );

  function automatic exp_t model(input logic [3:0] m, input logic [31:0] a, input logic [31:0] b);
    exp_t e;
    logic [32:0] t;
    logic sub_ovf;
    t = {1'b0, a} + {1'b0, ~b} + 33'd1;
    sub_ovf = (a[31] != b[31]) && (t[31] != a[31]);
    e.c = 1'b0;
    e.v = 1'b0;
    case (m)
      4'd0, 4'd1: begin
        t = {1'b0, a} + {1'b0, b};
        e.r = t[31:0];
        e.c = t[32];
        e.v = (m == 4'd0) && (a[31] == b[31]) && (t[31] != a[31]);
        e.tag = (m == 4'd0) ? "R1" : "R2";
      end
      4'd2, 4'd3: begin
        e.r = t[31:0];
        e.c = t[32];
        e.v = (m == 4'd2) && sub_ovf;
        e.tag = (m == 4'd2) ? "R3" : "R4";
      end
      4'd4: begin e.r = a & b;    e.tag = "R5"; end
      4'd5: begin e.r = a | b;    e.tag = "R5"; end
      4'd6: begin e.r = a ^ b;    e.tag = "R5"; end
      4'd7: begin e.r = ~(a | b); e.tag = "R5"; end
      4'd12: begin
        e.r = {31'b0, ($signed(a) < $signed(b))};
        e.v = sub_ovf;
        e.tag = "R6";
      end
      4'd13: begin
        e.r = {31'b0, (a < b)};
        e.tag = "R7";
      end
      default: begin e.r = '0; e.tag = "R8"; end
    endcase
    e.z = (e.r == 32'd0);
    return e;
  endfunction

  task automatic drive(input logic [3:0] m, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_code = m;
    op_a = a;
    op_b = b;
    sb_q.push_back(model(m, a, b));
  endtask

  task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // monitor: compares each registered output with the oldest expected item
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst && sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (result !== e.r) begin
          failures++;
          $display("FAIL %s result actual=%h expected=%h", e.tag, result, e.r);
        end
        check_bit(e.tag, "carry", carry_out, e.c);
        check_bit(e.tag, "overflow", overflow, e.v);
        check_bit("R9", "zero", zero, e.z);
      end
    end
  end

  initial begin
    // R10: reset state
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (result !== 32'd0) begin
      failures++;
      $display("FAIL R10 reset result actual=%h expected=%h", result, 32'd0);
    end
    check_bit("R10", "reset carry", carry_out, 1'b0);
    check_bit("R10", "reset overflow", overflow, 1'b0);
    check_bit("R10", "reset zero", zero, 1'b1);
    @(negedge clk);
    rst = 1'b0;

    // R1 signed add: overflow, wrap to zero with carry
    drive(4'd0, 32'h7FFF_FFFF, 32'h0000_0001);
    drive(4'd0, 32'hFFFF_FFFF, 32'h0000_0001);
    drive(4'd0, 32'h8000_0000, 32'h8000_0000);
    drive(4'd0, 32'd100, 32'd23);
    // R2 unsigned add never overflows
    drive(4'd1, 32'h7FFF_FFFF, 32'h0000_0001);
    drive(4'd1, 32'hFFFF_FFFF, 32'h0000_0001);
    // R3 signed subtract
    drive(4'd2, 32'h8000_0000, 32'h0000_0001);
    drive(4'd2, 32'd5, 32'd5);
    drive(4'd2, 32'd3, 32'd9);
    // R4 unsigned subtract
    drive(4'd3, 32'h0000_0000, 32'h0000_0001);
    drive(4'd3, 32'h8000_0000, 32'h0000_0001);
    // R5 bitwise
    drive(4'd4, 32'hF0F0_1234, 32'hFF00_FF00);
    drive(4'd5, 32'hF0F0_1234, 32'h0F00_0001);
    drive(4'd6, 32'hAAAA_5555, 32'hAAAA_5555);
    drive(4'd7, 32'h0000_0000, 32'h0000_0000);
    drive(4'd7, 32'hFFFF_0000, 32'h0000_FFFF);
    // R6 signed compare, with and without subtraction overflow
    drive(4'd12, 32'h8000_0000, 32'h0000_0001);
    drive(4'd12, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    drive(4'd12, 32'hFFFF_FFFE, 32'hFFFF_FFFF);
    drive(4'd12, 32'd7, 32'd7);
    // R7 unsigned compare
    drive(4'd13, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    drive(4'd13, 32'hFFFF_FFFF, 32'h0000_0001);
    drive(4'd13, 32'd4, 32'd4);
    // R8 unused codes
    foreach (sb_q[i]) begin end
    for (int k = 8; k < 16; k++) begin
      if (k != 12 && k != 13) drive(4'(k), 32'hFFFF_FFFF, 32'h0000_0001);
    end
    // random sweep over valid codes
    for (int n = 0; n < 2000; n++) begin
      logic [3:0] m;
      int pick;
      pick = $urandom_range(0, 9);
      m = (pick < 8) ? 4'(pick) : 4'(pick + 4);
      drive(m, $urandom(), (n % 7 == 0) ? 32'h8000_0000 : $urandom());
    end

    while (sb_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule